// File: doc/BRIEF.md
# Battery Charge Phase Controller

This block sequences one charge cycle of a nickel-based cell pack. It works from digital condition flags that comparators elsewhere produce: the cell is over its maximum voltage, the pack is colder than the cutoff threshold (the thermistor voltage is at or below the cutoff level), the pack is above the power-down level, and a voltage-slope termination event has fired. It also takes a charge-hold input, a decoded three-level rate selection and a single-cycle timebase tick. It walks the charge through a qualification step, fast charge, an optional top-off phase and pulse-trickle maintenance, and it has a low-power sleep phase.

The outputs are open-drain controls, each modelled by a flag that reads 1 when the pin floats. The charge-control pin floats to let current flow. The status LED pin is pulled low only while fast charge runs. A three-bit phase code tells a separate pulse modulator which duty pattern to apply to the charge-control pin in the top-off and trickle phases. A safety timer counts whole seconds, built from `TICK_DIV` ticks. It bounds fast charge and then, after a restart, top-off. At the start of fast charge a hold-off window ignores slope events.

Top module: `charge_sequencer`

## Requirements
- R1: Leaving reset, or a fall of `cell_hi` from 1 to 0 (a pack being inserted), starts a new cycle. The phase code goes to QUALIFY (0) for exactly one cycle. A `bat_pd` input that is high overrides this and gives SLEEP.
- R2: From QUALIFY the block enters FAST (1) when `cell_hi` is 0 and `temp_cold` is 0. Otherwise it enters TRICKLE (3) and stays there until the next new cycle.
- R3: FAST ends on any of the following: `cell_hi` is high, `temp_cold` is high, the safety timer has expired, or `slope_evt` is high outside the hold-off window.
- R4: `tm_sel` encodes the rate: 00 is low, 01 is mid, and 10 or 11 is high. The safety limits are `LIM_LO`, `LIM_MID` and `LIM_HI` seconds (defaults 4800, 9600 and 2400), and one second is `TICK_DIV` ticks. The timer counts only in FAST and TOPOFF, restarts from zero when either phase is entered, and has no limit in TRICKLE.
- R5: When FAST ends with `cell_hi` and `temp_cold` both low, the low and mid rates go to TOPOFF (2). The high rate goes to TRICKLE. In every other case the phase goes to TRICKLE. TOPOFF ends only on `cell_hi`, `temp_cold` or timer expiry, and `slope_evt` has no effect on it.
- R6: For the first `HOLD_LO`, `HOLD_MID` or `HOLD_HI` seconds of FAST (defaults 300, 600 and 150, chosen by rate), `slope_evt` is ignored. `cell_hi` and `temp_cold` still end FAST during this window.
- R7: `led_hiz` is 0 only while the held phase is FAST, and it is 1 in every other phase.
- R8: While `inhibit` is high, the held phase, the timer and its tick divider do not move. The phase code reads TRICKLE and `led_hiz` keeps its value. When `inhibit` falls, operation resumes from the same phase and count.
- R9: While `bat_pd` is high the phase is SLEEP (4), and the phase code shows SLEEP in the same cycle. When `bat_pd` falls, the block enters TRICKLE.
- R10: `cc_hiz` is 1 when the phase code is FAST or SLEEP and 0 in every other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle timebase pulse |
| tm_sel | input | 2 | Rate select: 00 low, 01 mid, 1x high |
| cell_hi | input | 1 | Cell voltage at or above the maximum |
| temp_cold | input | 1 | Temperature sense at or below the cutoff |
| bat_pd | input | 1 | Pack voltage above the power-down level |
| slope_evt | input | 1 | Peak or negative-slope termination event |
| inhibit | input | 1 | Charge hold |
| phase_code | output | 3 | Phase for the pulse modulator: 0 qualify, 1 fast, 2 top-off, 3 trickle, 4 sleep |
| cc_hiz | output | 1 | Charge-control pin floats (current flows) |
| led_hiz | output | 1 | Status LED pin floats |

## Verification
The assertions assume that the flags are synchronous to `clk`. They also assume that `tm_sel` holds still while a charge is in progress, and that `slope_evt` and `tick` are single-cycle or level signals sampled at the clock edge. The stimulus drives every input on the falling edge and changes `tm_sel` only just before a new cycle starts. It shortens the limits and sets `TICK_DIV` to 2, so that every phase reaches its timer expiry. A behavioural model in the bench follows each phase and count, and its outputs are compared with the block's outputs on every cycle. The `tick` input is also driven in an irregular pattern, to exercise the divider.

// File: rtl/chg_pkg.sv
// Shared types for the charge phase controller.
// Assumes: phase codes are consumed by an external pulse modulator.
package chg_pkg;
    typedef enum logic [2:0] {
        PH_QUALIFY = 3'd0,
        PH_FAST    = 3'd1,
        PH_TOPOFF  = 3'd2,
        PH_TRICKLE = 3'd3,
        PH_SLEEP   = 3'd4
    } phase_e;

    localparam logic [1:0] TM_LOW = 2'b00;
    localparam logic [1:0] TM_MID = 2'b01;
endpackage

// File: rtl/chg_tick_div.sv
// Divides timebase ticks into one-second strobes.
// Assumes: tick is a single-cycle pulse; clr restarts the second in progress.
module chg_tick_div #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic sec
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] cnt;

    assign sec = run && tick && (cnt == LAST);

    // Count ticks while running; wrap on each completed second.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   cnt <= '0;
        else if (run && tick) cnt <= sec ? '0 : cnt + 1'b1;
    end

    p_div_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/chg_safety_timer.sv
// Elapsed-seconds counter with a rate-selected limit and hold-off window.
// Assumes: tm_sel is stable for the duration of a phase.
module chg_safety_timer #(
    parameter int LIM_LO   = 4800,
    parameter int LIM_MID  = 9600,
    parameter int LIM_HI   = 2400,
    parameter int HOLD_LO  = 300,
    parameter int HOLD_MID = 600,
    parameter int HOLD_HI  = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       sec,
    input  logic [1:0] tm_sel,
    output logic       expired,
    output logic       in_hold
);
    import chg_pkg::*;

    localparam int CNT_W = $clog2(LIM_LO + LIM_MID + LIM_HI + 2);

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] hold;

    // Select the limit and hold-off length for the rate in use.
    always_comb begin
        case (tm_sel)
            TM_LOW:  begin lim = CNT_W'(LIM_LO);  hold = CNT_W'(HOLD_LO);  end
            TM_MID:  begin lim = CNT_W'(LIM_MID); hold = CNT_W'(HOLD_MID); end
            default: begin lim = CNT_W'(LIM_HI);  hold = CNT_W'(HOLD_HI);  end
        endcase
    end

    assign expired = (elapsed >= lim);
    assign in_hold = (elapsed < hold);

    // Count whole seconds; saturate rather than wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                     elapsed <= '0;
        else if (run && sec && (elapsed != '1)) elapsed <= elapsed + 1'b1;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> elapsed >= $past(elapsed));
    p_freeze_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(elapsed));
endmodule

// File: rtl/charge_sequencer.sv
// Charge cycle sequencer: qualify, fast, optional top-off, trickle, sleep.
// Assumes: all flags are synchronous to clk; analog sensing is external.
module charge_sequencer #(
    parameter int TICK_DIV = 1000,
    parameter int LIM_LO   = 4800,
    parameter int LIM_MID  = 9600,
    parameter int LIM_HI   = 2400,
    parameter int HOLD_LO  = 300,
    parameter int HOLD_MID = 600,
    parameter int HOLD_HI  = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] tm_sel,
    input  logic       cell_hi,
    input  logic       temp_cold,
    input  logic       bat_pd,
    input  logic       slope_evt,
    input  logic       inhibit,
    output logic [2:0] phase_code,
    output logic       cc_hiz,
    output logic       led_hiz
);
    import chg_pkg::*;

    phase_e state_q, state_d, shown;
    logic   cell_hi_q, new_cycle, run, clr, sec, expired, in_hold;
    logic   tm_high, fast_end, top_end;

    assign new_cycle = cell_hi_q && !cell_hi;
    assign run       = ((state_q == PH_FAST) || (state_q == PH_TOPOFF)) && !inhibit && !bat_pd;
    assign clr       = (state_d != state_q);
    assign tm_high   = tm_sel[1];
    assign fast_end  = cell_hi || temp_cold || expired || (slope_evt && !in_hold);
    assign top_end   = cell_hi || temp_cold || expired;

    chg_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .tick(tick), .sec(sec)
    );

    chg_safety_timer #(
        .LIM_LO(LIM_LO), .LIM_MID(LIM_MID), .LIM_HI(LIM_HI),
        .HOLD_LO(HOLD_LO), .HOLD_MID(HOLD_MID), .HOLD_HI(HOLD_HI)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .sec(sec),
        .tm_sel(tm_sel), .expired(expired), .in_hold(in_hold)
    );

    // Next phase: sleep, then new cycle, then wake, then hold, then normal flow.
    always_comb begin
        state_d = state_q;
        if (bat_pd)                    state_d = PH_SLEEP;
        else if (new_cycle)            state_d = PH_QUALIFY;
        else if (state_q == PH_SLEEP)  state_d = PH_TRICKLE;
        else if (!inhibit) begin
            case (state_q)
                PH_QUALIFY: state_d = (!cell_hi && !temp_cold) ? PH_FAST : PH_TRICKLE;
                PH_FAST:    if (fast_end)
                                state_d = (!tm_high && !cell_hi && !temp_cold) ? PH_TOPOFF : PH_TRICKLE;
                PH_TOPOFF:  if (top_end) state_d = PH_TRICKLE;
                default:    state_d = state_q;
            endcase
        end
    end

    // Phase register and insertion-edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PH_QUALIFY;
            cell_hi_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cell_hi_q <= cell_hi;
        end
    end

    // Shown phase: sleep at once; a held active phase reads as trickle.
    always_comb begin
        if (bat_pd)                       shown = PH_SLEEP;
        else if (inhibit && (state_q != PH_SLEEP)) shown = PH_TRICKLE;
        else                              shown = state_q;
    end

    assign phase_code = shown;
    assign cc_hiz     = (shown == PH_FAST) || (shown == PH_SLEEP);
    assign led_hiz    = bat_pd || (state_q != PH_FAST);

    p_cycle_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cycle && !bat_pd) |=> state_q == PH_QUALIFY);
    p_qualify_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_QUALIFY && !inhibit && !bat_pd && !new_cycle) |=> state_q != PH_QUALIFY);
    p_no_topoff_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FAST && tm_high) |=> state_q != PH_TOPOFF);
    p_hold_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FAST && in_hold && !cell_hi && !temp_cold && !expired
         && !inhibit && !bat_pd && !new_cycle) |=> state_q == PH_FAST);
    p_inhibit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !bat_pd && !new_cycle && state_q != PH_SLEEP) |=> $stable(state_q));
    p_sleep_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bat_pd |=> state_q == PH_SLEEP);
    p_wake_trickle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SLEEP && !bat_pd && !new_cycle) |=> state_q == PH_TRICKLE);
endmodule

// File: tb/charge_sequencer_test.sv
module charge_sequencer_test;
    localparam int DIV = 2;
    localparam int L_LO = 40, L_MID = 80, L_HI = 20;
    localparam int H_LO = 10, H_MID = 20, H_HI = 5;

    logic clk = 0, rst_n = 0, tick = 1;
    logic [1:0] tm_sel = 2'b01;
    logic cell_hi = 0, temp_cold = 0, bat_pd = 0, slope_evt = 0, inhibit = 0;
    logic [2:0] phase_code;
    logic cc_hiz, led_hiz;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    charge_sequencer #(
        .TICK_DIV(DIV), .LIM_LO(L_LO), .LIM_MID(L_MID), .LIM_HI(L_HI),
        .HOLD_LO(H_LO), .HOLD_MID(H_MID), .HOLD_HI(H_HI)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tm_sel(tm_sel), .cell_hi(cell_hi),
        .temp_cold(temp_cold), .bat_pd(bat_pd), .slope_evt(slope_evt),
        .inhibit(inhibit), .phase_code(phase_code), .cc_hiz(cc_hiz), .led_hiz(led_hiz)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int lim_of(input logic [1:0] t);
        return (t == 2'b00) ? L_LO : (t == 2'b01) ? L_MID : L_HI;
    endfunction
    function automatic int hold_of(input logic [1:0] t);
        return (t == 2'b00) ? H_LO : (t == 2'b01) ? H_MID : H_HI;
    endfunction

    // Behavioural reference: phase 0..4, elapsed seconds, tick count.
    int m_ph = 0, m_el = 0, m_dv = 0;
    bit m_prev = 0;
    always @(posedge clk) begin
        int nx;
        if (!rst_n) begin
            m_ph = 0; m_el = 0; m_dv = 0; m_prev = 0;
        end else begin
            nx = m_ph;
            if (bat_pd) nx = 4;
            else if (m_prev && !cell_hi) nx = 0;
            else if (m_ph == 4) nx = 3;
            else if (!inhibit) begin
                if (m_ph == 0) nx = (!cell_hi && !temp_cold) ? 1 : 3;
                else if (m_ph == 1) begin
                    if (cell_hi || temp_cold || m_el >= lim_of(tm_sel)
                        || (slope_evt && m_el >= hold_of(tm_sel)))
                        nx = (!tm_sel[1] && !cell_hi && !temp_cold) ? 2 : 3;
                end else if (m_ph == 2) begin
                    if (cell_hi || temp_cold || m_el >= lim_of(tm_sel)) nx = 3;
                end
            end
            if (nx != m_ph) begin
                m_el = 0; m_dv = 0;
            end else if ((m_ph == 1 || m_ph == 2) && !inhibit && !bat_pd && tick) begin
                if (m_dv == DIV - 1) begin m_dv = 0; m_el++; end
                else m_dv++;
            end
            m_ph = nx;
            m_prev = cell_hi;
        end
    end

    // Compare outputs with the model in every cycle, away from the edge.
    always @(posedge clk) begin
        int shown;
        #2;
        cyc++;
        shown = bat_pd ? 4 : (inhibit && m_ph != 4) ? 3 : m_ph;
        check({cur_req, " phase"}, phase_code, shown);
        check({cur_req, " R10 cc"}, cc_hiz, (shown == 1 || shown == 4) ? 1 : 0);
        check({cur_req, " R7 led"}, led_hiz, (!bat_pd && m_ph == 1) ? 0 : 1);
    end

    always @(posedge clk) if (cyc > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected < 100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic insert_pack();
        @(negedge clk) cell_hi = 1;
        @(negedge clk) cell_hi = 0;
    endtask
    task automatic pulse_slope();
        @(negedge clk) slope_evt = 1;
        @(negedge clk) slope_evt = 0;
    endtask

    initial begin
        wait_n(3);
        check("R1 reset phase", phase_code, 0);
        check("R7 reset led", led_hiz, 1);
        rst_n = 1;
        // Mid rate: fast to timer expiry, top-off to expiry, trickle.
        cur_req = "R4 R5";
        wait_n(2);
        check("R2 fast entry", phase_code, 1);
        wait_n(420);
        check("R4 mid chain to trickle", phase_code, 3);
        // High rate: masked slope in hold-off, then slope ends fast.
        cur_req = "R6";
        tm_sel = 2'b10;
        insert_pack();
        wait_n(1);
        check("R1 qualify", phase_code, 0);
        wait_n(4);
        pulse_slope();
        wait_n(2);
        check("R6 slope masked", phase_code, 1);
        cur_req = "R3";
        wait_n(20);
        pulse_slope();
        wait_n(2);
        check("R5 high skips top-off", phase_code, 3);
        // Cold pack at qualify goes to trickle.
        cur_req = "R2";
        @(negedge clk) temp_cold = 1;
        insert_pack();
        wait_n(3);
        pulse_slope();
        check("R2 cold qualify", phase_code, 3);
        @(negedge clk) temp_cold = 0;
        wait_n(10);
        check("R2 trickle persists", phase_code, 3);
        // Low rate with inhibit in fast; slope ignored in top-off.
        cur_req = "R8";
        tm_sel = 2'b00;
        insert_pack();
        wait_n(20);
        @(negedge clk) inhibit = 1;
        wait_n(60);
        check("R8 held shows trickle", phase_code, 3);
        check("R8 led frozen", led_hiz, 0);
        @(negedge clk) inhibit = 0;
        wait_n(40);
        check("R8 resumed fast", phase_code, 1);
        wait_n(40);
        check("R4 low top-off", phase_code, 2);
        cur_req = "R5";
        pulse_slope();
        wait_n(2);
        check("R5 slope ignored in top-off", phase_code, 2);
        @(negedge clk) temp_cold = 1;
        wait_n(2);
        check("R5 cold ends top-off", phase_code, 3);
        @(negedge clk) temp_cold = 0;
        // Mid rate: cold ends fast after hold-off; no top-off.
        cur_req = "R3";
        tm_sel = 2'b01;
        insert_pack();
        wait_n(50);
        @(negedge clk) temp_cold = 1;
        wait_n(2);
        check("R3 cold ends fast", phase_code, 3);
        @(negedge clk) temp_cold = 0;
        // Sleep during fast, then wake to trickle.
        cur_req = "R9";
        insert_pack();
        wait_n(10);
        @(negedge clk) bat_pd = 1;
        #1 check("R9 sleep at once", phase_code, 4);
        check("R9 cc floats", cc_hiz, 1);
        check("R9 led floats", led_hiz, 1);
        wait_n(5);
        @(negedge clk) bat_pd = 0;
        wait_n(2);
        check("R9 wake trickle", phase_code, 3);
        // Irregular ticks, high rate, timer expiry.
        cur_req = "R4 div";
        tm_sel = 2'b11;
        insert_pack();
        for (int i = 0; i < 200; i++) @(negedge clk) tick = ((i % 3) != 1);
        tick = 1;
        check("R4 high expiry", phase_code, 3);
        // Slope ends mid fast into top-off; inhibit inside top-off.
        cur_req = "R8 top";
        tm_sel = 2'b01;
        insert_pack();
        wait_n(50);
        pulse_slope();
        wait_n(2);
        check("R5 mid top-off after slope", phase_code, 2);
        @(negedge clk) inhibit = 1;
        wait_n(30);
        @(negedge clk) inhibit = 0;
        wait_n(200);
        check("R8 top-off resumed to expiry", phase_code, 3);
        wait_n(2);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule